// File: doc/BRIEF.md
# Near-Memory Property Prefetch Address Translator

This block sits beside a memory controller and turns virtual prefetch addresses for graph property data into physical prefetches. Each address arrives with the ID of the core that should receive the line. The block looks the page up in a small translation cache that holds property-page mappings only. It writes the translated address, still tagged with its core, into a physical address buffer. A checking stage then drains that buffer one entry at a time. For each entry it asks the coherence engine whether the line is already on chip and routes the prefetch on that answer.

Misses go out on a page-walk request/response port, and only one walk is open at a time. An address whose walk reports a page fault is dropped and not retried. Shootdown notices arrive on their own port and carry the structure-tag bit of the invalidated core-side entry. Only notices whose tag is 0 touch the cache. When the physical buffer is full, the block stops accepting virtual addresses, which holds the upstream queue.

Top module: `pfx_translator`

## Requirements
- R1: While reset is held, and afterwards until input arrives, `va_ready`, `walk_req_valid`, `coh_req_valid`, `dram_pf_valid` and `l2_copy_valid` are all 0.
- R2: A virtual address whose page is cached is translated without a walk. The physical address is the cached page number above the unchanged low `PAGE_W` offset bits, and it keeps the core ID.
- R3: On a miss, the block raises `walk_req_valid` for exactly one cycle with the page number on `walk_req_vpn`. It opens no second walk until the response arrives. The missing address waits at the head of the queue, so order is kept.
- R4: A walk response with `walk_rsp_fault` = 1 removes the head address. No output is produced for it, nothing is written into the cache, and a later address on the same page starts a new walk.
- R5: The cache holds `TLB_ENTRIES` mappings. Fills go to slots in round-robin order, starting at slot 0 after reset, so the slot filled longest ago is the one replaced.
- R6: A shootdown (`sd_valid` = 1) with `sd_struct` = 0 removes any cached mapping for `sd_vpn` from the next cycle on. A shootdown with `sd_struct` = 1 changes nothing.
- R7: Translated addresses wait in a FIFO of `PA_DEPTH` entries. When it is full, `va_ready` stays 0 and nothing is lost. At most `PA_DEPTH` + 1 accepted addresses are waiting for a result at any time.
- R8: Each buffered entry produces one `coh_req_valid` pulse carrying its address. `coh_hit` is sampled exactly `CHK_LAT` cycles after the request cycle, and the routing output is driven in the next cycle. No new request is made before then.
- R9: If `coh_hit` = 0 (line not on chip), the block issues a one-cycle `dram_pf_valid`, a DRAM prefetch whose line fills both the LLC and that core's L2. If `coh_hit` = 1, it issues a one-cycle `l2_copy_valid`, a copy from the inclusive LLC into that core's L2 only. The two are never raised together.
- R10: Routing outputs appear in the order the virtual addresses were accepted, one per non-faulting address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| va_valid | input | 1 | A virtual address is at the head of the upstream queue |
| va_ready | output | 1 | The head address is consumed this cycle |
| va_addr | input | VA_W | Virtual address of the property line |
| va_core | input | CORE_W | Core that receives the prefetched line |
| walk_req_valid | output | 1 | One-cycle page-walk request |
| walk_req_vpn | output | VA_W-PAGE_W | Virtual page number to walk |
| walk_rsp_valid | input | 1 | Walk result is valid |
| walk_rsp_fault | input | 1 | The walk reported a page fault |
| walk_rsp_ppn | input | PA_W-PAGE_W | Physical page number from the walk |
| sd_valid | input | 1 | Shootdown notice |
| sd_vpn | input | VA_W-PAGE_W | Page number being invalidated |
| sd_struct | input | 1 | Structure-tag bit of the invalidated core-side entry |
| coh_req_valid | output | 1 | One-cycle coherence query |
| coh_req_addr | output | PA_W | Physical address being queried |
| coh_hit | input | 1 | Line is on chip, valid CHK_LAT cycles after the query |
| dram_pf_valid | output | 1 | Queue a DRAM prefetch filling the LLC and the core's L2 |
| dram_pf_addr | output | PA_W | Physical address of the DRAM prefetch |
| dram_pf_core | output | CORE_W | Destination core of the DRAM prefetch |
| l2_copy_valid | output | 1 | Copy the line from the LLC into the core's L2 |
| l2_copy_addr | output | PA_W | Physical address of the copy |
| l2_copy_core | output | CORE_W | Destination core of the copy |

## Verification
On every cycle the assertions check four things: the walk request is a single-cycle pulse, a faulting walk empties the head in the next cycle, the buffer never takes a push while full, and structure-tagged shootdowns leave the cache unchanged. They also check that each routing decision lands exactly `CHK_LAT` + 1 cycles after its coherence query, and that only one of the two routes fires. Some behaviour only the bench scenarios can show, because it depends on sequences: round-robin eviction and the refetch after a shootdown, both seen through the count of walk requests; that nothing is lost or reordered under backpressure; and that each address and core reaches the route that matches the engine's answer. The bench's coherence model gives the opposite answer outside the exact sampling cycle, so a timing slip shows up as a wrong route.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
   typedef enum logic [1:0] {
      XL_IDLE = 2'd0,
      XL_WALK = 2'd1,
      XL_DROP = 2'd2
   } xl_state_e;
endpackage

// File: rtl/pfx_fifo.sv
module pfx_fifo #(
   parameter int WIDTH = 42,
   parameter int DEPTH = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             full,
   output logic             empty
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("pfx_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [AW-1:0]    wptr_q, rptr_q;
   logic [AW:0]      cnt_q;

   assign full  = (cnt_q == (AW+1)'(DEPTH));
   assign empty = (cnt_q == '0);
   assign rdata = mem_q[rptr_q];

   always_ff @(posedge clk) begin
      if (push) mem_q[wptr_q] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) wptr_q <= wptr_q + 1'b1;
         if (pop)  rptr_q <= rptr_q + 1'b1;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R7
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/pfx_tlb.sv
module pfx_tlb #(
   parameter int ENTRIES = 128,
   parameter int VPN_W   = 36,
   parameter int PPN_W   = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [PPN_W-1:0] lk_ppn,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             sd_valid,
   input  logic [VPN_W-1:0] sd_vpn,
   input  logic             sd_struct
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("pfx_tlb: ENTRIES must be at least 2");
   end

   logic [ENTRIES-1:0] valid_q;
   logic [ENTRIES-1:0] match;
   logic [VPN_W-1:0]   vpn_q [ENTRIES];
   logic [PPN_W-1:0]   ppn_q [ENTRIES];
   logic [IDX_W-1:0]   rr_q, rr_next;
   logic               kill;

   // victim pointer: natural wrap for power-of-two sizes, explicit otherwise
   if ((1 << IDX_W) == ENTRIES) begin : g_rr_pow2
      assign rr_next = rr_q + 1'b1;
   end else begin : g_rr_mod
      assign rr_next = (rr_q == IDX_W'(ENTRIES-1)) ? '0 : rr_q + 1'b1;
   end

   assign kill = sd_valid && !sd_struct;

   always_comb begin
      lk_ppn = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         match[i] = valid_q[i] && (vpn_q[i] == lk_vpn);
         if (match[i]) lk_ppn = lk_ppn | ppn_q[i];
      end
      lk_hit = |match;
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         vpn_q[rr_q] <= fill_vpn;
         ppn_q[rr_q] <= fill_ppn;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         rr_q    <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (kill && valid_q[i] && (vpn_q[i] == sd_vpn)) valid_q[i] <= 1'b0;
         end
         if (fill_en) begin
            valid_q[rr_q] <= 1'b1;
            rr_q          <= rr_next;
         end
      end
   end

   // R2
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
   // R5
   fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> valid_q[$past(rr_q)]);
   // R6
   struct_sd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_valid && sd_struct && !fill_en) |=> $stable(valid_q));
endmodule

// File: rtl/pfx_coh_stage.sv
module pfx_coh_stage #(
   parameter int PA_W    = 40,
   parameter int CORE_W  = 2,
   parameter int CHK_LAT = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              q_empty,
   input  logic [PA_W-1:0]   q_pa,
   input  logic [CORE_W-1:0] q_core,
   output logic              q_pop,
   output logic              coh_req_valid,
   output logic [PA_W-1:0]   coh_req_addr,
   input  logic              coh_hit,
   output logic              dram_pf_valid,
   output logic [PA_W-1:0]   dram_pf_addr,
   output logic [CORE_W-1:0] dram_pf_core,
   output logic              l2_copy_valid,
   output logic [PA_W-1:0]   l2_copy_addr,
   output logic [CORE_W-1:0] l2_copy_core
);
   localparam int CNT_W = $clog2(CHK_LAT + 1);

   if (CHK_LAT < 1) begin : g_bad_lat
      $error("pfx_coh_stage: CHK_LAT must be at least 1");
   end

   logic              busy_q, req_q, dram_q, l2_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [PA_W-1:0]   pa_q;
   logic [CORE_W-1:0] core_q;

   assign q_pop         = !busy_q && !q_empty;
   assign coh_req_valid = req_q;
   assign coh_req_addr  = pa_q;
   assign dram_pf_valid = dram_q;
   assign dram_pf_addr  = pa_q;
   assign dram_pf_core  = core_q;
   assign l2_copy_valid = l2_q;
   assign l2_copy_addr  = pa_q;
   assign l2_copy_core  = core_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         req_q  <= 1'b0;
         dram_q <= 1'b0;
         l2_q   <= 1'b0;
         cnt_q  <= '0;
         pa_q   <= '0;
         core_q <= '0;
      end else begin
         req_q  <= q_pop;
         dram_q <= 1'b0;
         l2_q   <= 1'b0;
         if (q_pop) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            pa_q   <= q_pa;
            core_q <= q_core;
         end else if (busy_q) begin
            if (cnt_q == CNT_W'(CHK_LAT)) begin
               busy_q <= 1'b0;
               dram_q <= !coh_hit;
               l2_q   <= coh_hit;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   // checker-side cycle count since the last query
   logic [CNT_W:0] since_q;
   always_ff @(posedge clk) begin
      if (!rst_n) since_q <= '0;
      else if (req_q) since_q <= 1;
      else if (since_q != '0 && since_q <= (CNT_W+1)'(CHK_LAT + 1)) since_q <= since_q + 1'b1;
   end

   // R8
   route_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_q || l2_q) |-> since_q == (CNT_W+1)'(CHK_LAT + 1));
   // R8
   one_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |=> !req_q);
   // R9
   one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dram_q && l2_q));
endmodule

// File: rtl/pfx_translator.sv
module pfx_translator
   import pfx_pkg::*;
#(
   parameter int VA_W        = 48,
   parameter int PA_W        = 40,
   parameter int PAGE_W      = 12,
   parameter int CORE_W      = 2,
   parameter int TLB_ENTRIES = 128,
   parameter int PA_DEPTH    = 512,
   parameter int CHK_LAT     = 10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   va_valid,
   output logic                   va_ready,
   input  logic [VA_W-1:0]        va_addr,
   input  logic [CORE_W-1:0]      va_core,
   output logic                   walk_req_valid,
   output logic [VA_W-PAGE_W-1:0] walk_req_vpn,
   input  logic                   walk_rsp_valid,
   input  logic                   walk_rsp_fault,
   input  logic [PA_W-PAGE_W-1:0] walk_rsp_ppn,
   input  logic                   sd_valid,
   input  logic [VA_W-PAGE_W-1:0] sd_vpn,
   input  logic                   sd_struct,
   output logic                   coh_req_valid,
   output logic [PA_W-1:0]        coh_req_addr,
   input  logic                   coh_hit,
   output logic                   dram_pf_valid,
   output logic [PA_W-1:0]        dram_pf_addr,
   output logic [CORE_W-1:0]      dram_pf_core,
   output logic                   l2_copy_valid,
   output logic [PA_W-1:0]        l2_copy_addr,
   output logic [CORE_W-1:0]      l2_copy_core
);
   localparam int VPN_W = VA_W - PAGE_W;
   localparam int PPN_W = PA_W - PAGE_W;
   localparam int ENT_W = CORE_W + PA_W;

   if (PAGE_W < 1 || VPN_W < 1 || PPN_W < 1 || CORE_W < 1) begin : g_bad_widths
      $error("pfx_translator: address, page and core widths are inconsistent");
   end

   xl_state_e         state_q;
   logic              walk_q;
   logic [VPN_W-1:0]  walk_vpn_q;
   logic [VPN_W-1:0]  head_vpn;
   logic              tlb_hit, fill_en;
   logic [PPN_W-1:0]  tlb_ppn;
   logic              pa_push, pa_pop, pa_full, pa_empty;
   logic [ENT_W-1:0]  pa_wdata, pa_rdata;

   assign head_vpn       = va_addr[VA_W-1:PAGE_W];
   assign walk_req_valid = walk_q;
   assign walk_req_vpn   = walk_vpn_q;

   always_comb begin
      pa_push  = (state_q == XL_IDLE) && va_valid && tlb_hit && !pa_full;
      va_ready = pa_push || (state_q == XL_DROP);
      fill_en  = (state_q == XL_WALK) && walk_rsp_valid && !walk_rsp_fault;
      pa_wdata = {va_core, tlb_ppn, va_addr[PAGE_W-1:0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= XL_IDLE;
         walk_q     <= 1'b0;
         walk_vpn_q <= '0;
      end else begin
         walk_q <= 1'b0;
         case (state_q)
            XL_IDLE: if (va_valid && !tlb_hit) begin
               state_q    <= XL_WALK;
               walk_q     <= 1'b1;
               walk_vpn_q <= head_vpn;
            end
            XL_WALK: if (walk_rsp_valid) begin
               state_q <= walk_rsp_fault ? XL_DROP : XL_IDLE;
            end
            XL_DROP: state_q <= XL_IDLE;
            default: state_q <= XL_IDLE;
         endcase
      end
   end

   pfx_tlb #(
      .ENTRIES (TLB_ENTRIES),
      .VPN_W   (VPN_W),
      .PPN_W   (PPN_W)
   ) u_tlb (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_vpn    (head_vpn),
      .lk_hit    (tlb_hit),
      .lk_ppn    (tlb_ppn),
      .fill_en   (fill_en),
      .fill_vpn  (walk_vpn_q),
      .fill_ppn  (walk_rsp_ppn),
      .sd_valid  (sd_valid),
      .sd_vpn    (sd_vpn),
      .sd_struct (sd_struct)
   );

   pfx_fifo #(
      .WIDTH (ENT_W),
      .DEPTH (PA_DEPTH)
   ) u_pab (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (pa_push),
      .wdata (pa_wdata),
      .pop   (pa_pop),
      .rdata (pa_rdata),
      .full  (pa_full),
      .empty (pa_empty)
   );

   pfx_coh_stage #(
      .PA_W    (PA_W),
      .CORE_W  (CORE_W),
      .CHK_LAT (CHK_LAT)
   ) u_chk (
      .clk           (clk),
      .rst_n         (rst_n),
      .q_empty       (pa_empty),
      .q_pa          (pa_rdata[PA_W-1:0]),
      .q_core        (pa_rdata[ENT_W-1:PA_W]),
      .q_pop         (pa_pop),
      .coh_req_valid (coh_req_valid),
      .coh_req_addr  (coh_req_addr),
      .coh_hit       (coh_hit),
      .dram_pf_valid (dram_pf_valid),
      .dram_pf_addr  (dram_pf_addr),
      .dram_pf_core  (dram_pf_core),
      .l2_copy_valid (l2_copy_valid),
      .l2_copy_addr  (l2_copy_addr),
      .l2_copy_core  (l2_copy_core)
   );

   // R3
   walk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req_valid |=> !walk_req_valid);
   // R4
   fault_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == XL_WALK) && walk_rsp_valid && walk_rsp_fault) |=> (va_ready && !pa_push));
   // R3
   walk_holds_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req_valid |-> !va_ready);
endmodule

// File: tb/sim_pfx_translator.sv
module sim_pfx_translator;
   localparam int CLK_PERIOD = 10;
   localparam int VA_W = 48, PA_W = 40, PAGE_W = 12, CORE_W = 2;
   localparam int TLB_N = 4, DEPTH = 8, CHK = 10, WALK_DLY = 3;
   localparam int VPN_W = VA_W - PAGE_W, PPN_W = PA_W - PAGE_W;

   logic clk = 1'b0, rst_n = 1'b0;
   logic va_valid = 1'b0, va_ready;
   logic [VA_W-1:0] va_addr = '0;
   logic [CORE_W-1:0] va_core = '0;
   logic walk_req_valid, walk_rsp_valid = 1'b0, walk_rsp_fault = 1'b0;
   logic [VPN_W-1:0] walk_req_vpn;
   logic [PPN_W-1:0] walk_rsp_ppn = '0;
   logic sd_valid = 1'b0, sd_struct = 1'b0;
   logic [VPN_W-1:0] sd_vpn = '0;
   logic coh_req_valid, coh_hit = 1'b0;
   logic [PA_W-1:0] coh_req_addr, dram_pf_addr, l2_copy_addr;
   logic dram_pf_valid, l2_copy_valid;
   logic [CORE_W-1:0] dram_pf_core, l2_copy_core;

   always #(CLK_PERIOD/2) clk = ~clk;

   pfx_translator #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W), .CORE_W(CORE_W),
      .TLB_ENTRIES(TLB_N), .PA_DEPTH(DEPTH), .CHK_LAT(CHK)) u0 (.*);

   int checks = 0, fails = 0;
   int walks = 0, routed = 0, acc_ok = 0, max_inflight = 0;
   longint cyc = 0, last_req_cyc = 0;

   typedef struct { logic [PA_W-1:0] pa; logic [CORE_W-1:0] core; logic onchip; } exp_t;
   exp_t expq[$];
   logic [VA_W+CORE_W-1:0] vq[$];
   logic fire_s = 1'b0;

   function automatic logic is_fault(input logic [VPN_W-1:0] v); return v[3:0] == 4'hF; endfunction
   function automatic logic [PPN_W-1:0] map_ppn(input logic [VPN_W-1:0] v);
      return v[PPN_W-1:0] ^ 28'h5A5A5A5;
   endfunction
   function automatic logic on_chip(input logic [PA_W-1:0] pa); return pa[6]; endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   // driver: pushes the address upstream and the expected result into the scoreboard
   task automatic send(input logic [CORE_W-1:0] core, input logic [VPN_W-1:0] vpn, input logic [PAGE_W-1:0] off);
      exp_t e;
      vq.push_back({core, vpn, off});
      if (!is_fault(vpn)) begin
         e.pa = {map_ppn(vpn), off};
         e.core = core;
         e.onchip = on_chip(e.pa);
         expq.push_back(e);
      end
   endtask

   task automatic drain();
      while (vq.size() != 0 || expq.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic shoot(input logic [VPN_W-1:0] vpn, input logic st);
      @(negedge clk);
      sd_valid = 1'b1; sd_vpn = vpn; sd_struct = st;
      @(negedge clk);
      sd_valid = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   always @(posedge clk) fire_s <= va_valid && va_ready;

   // upstream queue model
   always @(negedge clk) begin
      cyc++;
      if (fire_s && vq.size() != 0) begin
         if (!is_fault(vq[0][VA_W-1:PAGE_W])) acc_ok++;
         void'(vq.pop_front());
      end
      va_valid = vq.size() != 0;
      if (vq.size() != 0) begin
         va_addr = vq[0][VA_W-1:0];
         va_core = vq[0][VA_W+CORE_W-1:VA_W];
      end
      if (acc_ok - routed > max_inflight) max_inflight = acc_ok - routed;
   end

   // page-walk responder
   int wcnt = 0;
   logic [VPN_W-1:0] wvpn = '0;
   always @(negedge clk) begin
      walk_rsp_valid = 1'b0;
      if (wcnt != 0) begin
         wcnt--;
         if (wcnt == 0) begin
            walk_rsp_valid = 1'b1;
            walk_rsp_fault = is_fault(wvpn);
            walk_rsp_ppn = map_ppn(wvpn);
         end
      end
      if (walk_req_valid) begin
         walks++;
         wcnt = WALK_DLY;
         wvpn = walk_req_vpn;
      end
   end

   // coherence engine: correct answer only in the exact sampling cycle
   int ck = 100;
   logic [PA_W-1:0] cpa = '0;
   always @(negedge clk) begin
      if (coh_req_valid) begin
         cpa = coh_req_addr; ck = 0; last_req_cyc = cyc;
      end else if (ck < 100) ck++;
      coh_hit = (ck == CHK) ? on_chip(cpa) : ~on_chip(cpa);
   end

   // monitor: pops the scoreboard as results appear
   always @(negedge clk) begin
      if (rst_n && (dram_pf_valid || l2_copy_valid)) begin
         exp_t e;
         routed++;
         check(!(dram_pf_valid && l2_copy_valid), "R9 single route", {dram_pf_valid, l2_copy_valid}, 1);
         check(cyc - last_req_cyc == CHK + 1, "R8 route latency", cyc - last_req_cyc, CHK + 1);
         if (expq.size() == 0) begin
            check(1'b0, "R10 unexpected output", routed, 0);
         end else begin
            e = expq.pop_front();
            if (l2_copy_valid) begin
               check(l2_copy_addr == e.pa && l2_copy_core == e.core, "R2 R10 copy address/core",
                     {l2_copy_core, l2_copy_addr}, {e.core, e.pa});
            end else begin
               check(dram_pf_addr == e.pa && dram_pf_core == e.core, "R2 R10 dram address/core",
                     {dram_pf_core, dram_pf_addr}, {e.core, e.pa});
            end
            check(l2_copy_valid == e.onchip, "R9 route choice", l2_copy_valid, e.onchip);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
      $finish;
   end

   initial begin
      int w0;
      localparam logic [VPN_W-1:0] P1 = 'h101, P2 = 'h202, P3 = 'h303, P4 = 'h404, P5 = 'h505, PF = 'h70F;
      repeat (3) @(negedge clk);
      // R1 reset state
      check({va_ready, walk_req_valid, coh_req_valid, dram_pf_valid, l2_copy_valid} == 0,
            "R1 outputs in reset", {va_ready, walk_req_valid, coh_req_valid, dram_pf_valid, l2_copy_valid}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check({va_ready, walk_req_valid, coh_req_valid, dram_pf_valid, l2_copy_valid} == 0,
            "R1 outputs idle after reset", {va_ready, walk_req_valid, coh_req_valid, dram_pf_valid, l2_copy_valid}, 0);

      // R2 R3: one miss then hits on the same page, both routes
      w0 = walks;
      send(1, P1, 12'h040); send(1, P1, 12'h000); send(2, P1, 12'hFC0);
      drain();
      check(walks - w0 == 1, "R2 R3 one walk per page", walks - w0, 1);

      // R3 R10: two pages interleaved from several cores
      w0 = walks;
      send(0, P2, 12'h080); send(3, P3, 12'h0C0); send(2, P2, 12'h100); send(1, P3, 12'h140);
      drain();
      check(walks - w0 == 2, "R3 interleaved pages walk once each", walks - w0, 2);

      // R4: faulting page is dropped, following address still served, retry walks again
      w0 = walks;
      send(3, PF, 12'h040); send(0, P1, 12'h200);
      drain();
      check(walks - w0 == 1, "R4 fault dropped", walks - w0, 1);
      w0 = walks;
      send(3, PF, 12'h080);
      drain();
      check(walks - w0 == 1, "R4 fault not cached", walks - w0, 1);

      // R5: slots P1,P2,P3 full, pointer at 3
      w0 = walks; send(0, P4, 12'h000); send(0, P5, 12'h040); drain();
      check(walks - w0 == 2, "R5 fills for P4 and P5", walks - w0, 2);
      w0 = walks; send(1, P2, 12'h000); drain();
      check(walks - w0 == 0, "R5 P2 survives", walks - w0, 0);
      w0 = walks; send(1, P1, 12'h000); drain();
      check(walks - w0 == 1, "R5 oldest P1 was evicted", walks - w0, 1);
      w0 = walks; send(2, P3, 12'h000); drain();
      check(walks - w0 == 0, "R5 P3 survives", walks - w0, 0);
      w0 = walks; send(2, P2, 12'h040); drain();
      check(walks - w0 == 1, "R5 P2 evicted next", walks - w0, 1);

      // R6: cache now P5,P1,P2,P4
      shoot(P4, 1'b1);
      w0 = walks; send(3, P4, 12'h0C0); drain();
      check(walks - w0 == 0, "R6 structure shootdown ignored", walks - w0, 0);
      shoot(P4, 1'b0);
      w0 = walks; send(3, P4, 12'h100); drain();
      check(walks - w0 == 1, "R6 property shootdown invalidates", walks - w0, 1);

      // R7: burst of hits overruns the checking stage
      max_inflight = 0;
      for (int i = 0; i < 24; i++) send(2'(i), P5, 12'(i * 64));
      drain();
      check(max_inflight <= DEPTH + 2, "R7 inflight bounded", max_inflight, DEPTH + 2);
      check(max_inflight >= DEPTH - 1, "R7 buffer filled", max_inflight, DEPTH);

      // R10: everything accounted for
      check(expq.size() == 0 && routed == acc_ok, "R10 all results delivered", routed, acc_ok);
      summary();
      $finish;
   end
endmodule